// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 17-bit virtual address into a 15-bit physical address by reading one entry from a flat page table. The table sits in a word-addressed memory and begins at the word held in a base register. Pages are 4 KiB. The low twelve address bits pass through unchanged. The five-bit virtual page number selects the entry, and that entry supplies a three-bit physical page number.

A requester offers one translation at a time, together with the kind of access it intends to make: read, write or instruction fetch. The walker reads the entry through its memory port. That port may take any number of cycles to answer. The walker then returns either a physical address or a fault code that separates a page that is not present from an access the page's rights forbid.

The base register can be written at any time. A write that arrives in the middle of a walk is held back until that walk has finished.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. The base register holds 0, so the first walk reads word address equal to the virtual page number.
- R2: Each accepted request (`req_valid` and `req_ready` both high at a clock edge) causes exactly one cycle of `mem_rd_en`, in the cycle after acceptance. That read is at word address base + VPN, where the VPN is `req_vaddr[16:12]`.
- R3: `req_ready` stays low from the cycle after acceptance until the cycle in which `rsp_valid` is high.
- R4: An entry word has three fields. Bit 5 is the present flag, bits 4:3 hold the rights code and bits 2:0 hold the physical page. On a permitted access the walker returns `rsp_fault` 00 and `rsp_paddr` = {physical page, `req_vaddr[11:0]`}.
- R5: If the present bit is 0, the walker returns `rsp_fault` 01 (not present), whatever the rights code or access kind.
- R6: Access kinds on `req_kind` are 00 read, 01 write, 10 fetch and 11 reserved. Rights code 00 (read-only) permits a read only. A write or a fetch to such a page returns `rsp_fault` 10 (protection).
- R7: Rights code 01 (read/write) permits reads and writes. A fetch to such a page returns `rsp_fault` 10.
- R8: Rights code 10 (executable) permits a fetch only. A read or a write to such a page returns `rsp_fault` 10.
- R9: On a present page, rights code 11 returns `rsp_fault` 10 for every access kind. Access kind 11 also returns `rsp_fault` 10 for every rights code.
- R10: A base write made while the walker is idle applies to the next accepted request, including a request accepted in the same cycle.
- R11: A base write made while a walk is in progress leaves that walk on the old base. The next walk uses the new value. If several writes arrive during one walk, the last of them wins.
- R12: Every request gets exactly one single-cycle `rsp_valid` pulse. `rsp_fault` only takes the values 00, 01 and 10, and on any fault `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 8 | New table base, as a word address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 17 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| mem_rd_en | output | 1 | One-cycle read strobe to the table memory |
| mem_rd_addr | output | 8 | Word address of the entry being read |
| mem_rd_valid | input | 1 | Memory returns the entry in this cycle |
| mem_rd_data | input | 6 | Entry word: present, rights[1:0], page[2:0] |
| rsp_valid | output | 1 | Result available for one cycle |
| rsp_paddr | output | 15 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
The assertions assume three things about the memory port. It answers each strobe with exactly one `mem_rd_valid`, that answer comes at least one cycle after the strobe, and it never raises `mem_rd_valid` unprompted. The bench's memory model respects all three. It counts down a latency of one to four cycles that the bench picks for each request, and it only answers a read it has captured.

The assertions also assume that the requester never changes a request in the cycle it is accepted. The bench drives requests only at falling edges while `req_ready` is high, and drops `req_valid` right after acceptance. Base writes during a walk are issued only once the memory strobe has been seen, so they always land in the waiting phase.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
// Shared types of the page table walker.
// Assumes: the 2-bit codes below are the encodings seen at the ports and in entry words.
package ptw_pkg;

    // Kind of access a request intends to make
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    // Rights code stored in a page table entry
    typedef enum logic [1:0] {
        AR_RDONLY = 2'b00,
        AR_RDWR   = 2'b01,
        AR_EXEC   = 2'b10,
        AR_BAD    = 2'b11
    } rights_e;

    // Result code of a walk
    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_PROT   = 2'b10
    } fault_e;

    // Walker sequencing
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } state_e;

endpackage

// File: rtl/ptw_base_reg.sv
`timescale 1ns/1ps
// Table base register with deferred update.
// A write while idle is taken at once. A write while busy is parked, and the
// parked value is applied in the first idle cycle. Later parked writes replace
// earlier ones.
// Assumes: busy stays high for the whole walk that must see a stable base.
module ptw_base_reg #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_o
);

    logic          pend_q;
    logic [AW-1:0] pend_data_q;

    // Update the base immediately when idle, or park the write while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o      <= '0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (!busy) begin
            if (wr_en) begin
                base_o <= wr_data;
            end else if (pend_q) begin
                base_o <= pend_data_q;
            end
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
        end
    end

endmodule

// File: rtl/ptw_rights_chk.sv
`timescale 1ns/1ps
// Combinational rights check: is this access kind permitted by this rights code.
// Assumes: the present bit is judged elsewhere; the reserved rights code and
// the reserved access kind are never permitted.
module ptw_rights_chk
    import ptw_pkg::*;
(
    input  acc_e    kind,
    input  rights_e rights,
    output logic    allowed
);

    // Permission table over rights code and access kind
    always_comb begin
        allowed = 1'b0;
        case (rights)
            AR_RDONLY: allowed = (kind == ACC_READ);
            AR_RDWR:   allowed = (kind == ACC_READ) || (kind == ACC_WRITE);
            AR_EXEC:   allowed = (kind == ACC_FETCH);
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
// Single-level page table walker.
// It accepts one translation at a time and reads the entry at base + VPN with a
// one-cycle strobe. It then waits for the memory's valid and returns either
// {physical page, offset} or a fault code as a one-cycle pulse.
// Assumes: the memory answers each strobe exactly once, no earlier than the
// cycle after it, and carries the entry in the low PTE_W bits of the word.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter  int VA_W   = 17,
    parameter  int PA_W   = 15,
    parameter  int OFF_W  = 12,
    parameter  int MEM_AW = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int PTE_W  = PPN_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [MEM_AW-1:0] base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);

    localparam int PRESENT_BIT = PTE_W - 1;
    localparam int RIGHTS_LSB  = PPN_W;

    state_e              state_q;
    logic [VPN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]    off_q;
    acc_e                kind_q;
    logic [MEM_AW-1:0]   base;
    logic                busy;
    logic                accept;
    logic                pte_present;
    rights_e             pte_rights;
    logic [PPN_W-1:0]    pte_ppn;
    logic                allowed;

    assign busy      = (state_q != ST_IDLE);
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign mem_rd_en = (state_q == ST_ISSUE);

    // Word address of the entry: base plus the zero-extended page number
    assign mem_rd_addr = base + MEM_AW'(vpn_q);

    // Split the returned entry into its fields
    assign pte_present = mem_rd_data[PRESENT_BIT];
    assign pte_rights  = rights_e'(mem_rd_data[RIGHTS_LSB +: 2]);
    assign pte_ppn     = mem_rd_data[PPN_W-1:0];

    ptw_base_reg #(
        .AW (MEM_AW)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_o  (base)
    );

    ptw_rights_chk u_rights (
        .kind    (kind_q),
        .rights  (pte_rights),
        .allowed (allowed)
    );

    // Sequence: idle -> strobe the read -> wait for the entry -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) state_q <= ST_ISSUE;
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT:  if (mem_rd_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the request fields for the length of the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            off_q  <= '0;
            kind_q <= ACC_READ;
        end else if (accept) begin
            vpn_q  <= req_vaddr[VA_W-1:OFF_W];
            off_q  <= req_vaddr[OFF_W-1:0];
            kind_q <= acc_e'(req_kind);
        end
    end

    // Form the result when the entry arrives; pulse valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b0;
            if (state_q == ST_WAIT && mem_rd_valid) begin
                rsp_valid <= 1'b1;
                if (!pte_present) begin
                    rsp_fault <= FLT_ABSENT;
                    rsp_paddr <= '0;
                end else if (!allowed) begin
                    rsp_fault <= FLT_PROT;
                    rsp_paddr <= '0;
                end else begin
                    rsp_fault <= FLT_NONE;
                    rsp_paddr <= {pte_ppn, off_q};
                end
            end
        end
    end

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
// Protocol checker for the page table walker, bound to every instance.
// Assumes: the memory answers each strobe once, and never in the strobe cycle.
module ptw_walker_chk #(
    parameter int PA_W  = 15,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             mem_rd_en,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault
);

    logic [OFF_W-1:0] off_seen_q;

    // Keep the offset of the accepted request, independently of the walker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_seen_q <= '0;
        end else if (req_valid && req_ready) begin
            off_seen_q <= req_off;
        end
    end

    AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> mem_rd_en); // R2
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |-> !req_ready); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault == 2'b00) |-> (rsp_paddr[OFF_W-1:0] == off_seen_q)); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R12
    AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_fault != 2'b11)); // R12
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0)); // R12

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .mem_rd_en (mem_rd_en),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every page number and access kind over two tables with
// varying memory latency, then exercises base writes while idle and while busy.
module ptw_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [7:0]  base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [5:0]  mem_rd_data = '0;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int tests = 0;
    int fails = 0;
    int lat = 1;
    int rd_cnt = 0;
    int cnt = 0;
    logic [7:0] cap_addr = '0;
    logic [5:0] mem [0:255];

    always #2 clk = ~clk;

    ptw_walker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_wr_en   (base_wr_en),
        .base_wr_data (base_wr_data),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .req_kind     (req_kind),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_fault    (rsp_fault)
    );

    // Memory model: capture the strobe, answer once after lat cycles
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_en) begin
            cap_addr <= mem_rd_addr;
            cnt      <= lat;
            rd_cnt   <= rd_cnt + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[cap_addr];
            end
        end
    end

    function automatic logic [5:0] pte_of(int vpn, int salt);
        logic       pres;
        logic [1:0] ar;
        logic [2:0] ppn;
        pres = (((vpn + salt) % 7) != 3);
        ar   = 2'((vpn + salt) % 4);
        ppn  = 3'((vpn * 5 + 1 + salt * 3) % 8);
        return {pres, ar, ppn};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One translation; optionally writes the base while the walk waits
    task automatic xlate(int vpn, int kind, int off, int lat_v, int exp_base,
                         int salt, string addr_tag, bit defer_wr, int new_base);
        int rd0;
        int cyc;
        bit ready_ok;
        bit seen;
        logic [5:0] pte;
        bit ok_acc;
        int exp_fault;
        int exp_pa;
        string rtag;
        ready_ok = 1'b1;
        lat = lat_v;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {vpn[4:0], off[11:0]};
        req_kind  = kind[1:0];
        rd0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        if (defer_wr) begin
            while (rd_cnt == rd0) @(negedge clk);
            base_wr_en   = 1'b1;
            base_wr_data = new_base[7:0];
            @(negedge clk);
            base_wr_en   = 1'b0;
        end
        cyc = 0;
        while (!rsp_valid && cyc < 50) begin
            if (req_ready) ready_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        seen = rsp_valid;
        chk(seen, "R12", "response pulse seen", int'(seen), 1);
        chk(ready_ok, "R3", "ready low during walk", int'(ready_ok), 1);
        chk(rd_cnt - rd0 == 1, "R2", "reads per request", rd_cnt - rd0, 1);
        chk(int'(cap_addr) == exp_base + vpn, addr_tag, "entry word address",
            int'(cap_addr), exp_base + vpn);
        pte = pte_of(vpn, salt);
        case (pte[4:3])
            2'b00:   ok_acc = (kind == 0);
            2'b01:   ok_acc = (kind == 0) || (kind == 1);
            2'b10:   ok_acc = (kind == 2);
            default: ok_acc = 1'b0;
        endcase
        if (kind == 3) ok_acc = 1'b0;
        if (!pte[5]) rtag = "R5";
        else if (kind == 3 || pte[4:3] == 2'b11) rtag = "R9";
        else if (pte[4:3] == 2'b00) rtag = "R6";
        else if (pte[4:3] == 2'b01) rtag = "R7";
        else rtag = "R8";
        exp_fault = !pte[5] ? 1 : (ok_acc ? 0 : 2);
        exp_pa    = (exp_fault == 0) ? (int'(pte[2:0]) * 4096 + off) : 0;
        chk(int'(rsp_fault) == exp_fault, rtag, "fault code", int'(rsp_fault), exp_fault);
        chk(int'(rsp_paddr) == exp_pa, (exp_fault == 0) ? "R4" : "R12",
            "physical address", int'(rsp_paddr), exp_pa);
        @(negedge clk);
        chk(!rsp_valid, "R12", "pulse lasts one cycle", int'(rsp_valid), 0);
    endtask

    task automatic sweep(int exp_base, int salt, string addr_tag);
        for (int v = 0; v < 32; v++) begin
            for (int k = 0; k < 4; k++) begin
                xlate(v, k, (v * 37 + k * 101 + 7) % 4096, (v + k) % 4 + 1,
                      exp_base, salt, addr_tag, 1'b0, 0);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int v = 0; v < 32; v++) begin
            mem[v]      = pte_of(v, 0);
            mem[64 + v] = pte_of(v, 1);
        end
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        // First walk shows the reset base of 0
        xlate(5, 0, 12'h3c1, 2, 0, 0, "R1", 1'b0, 0);
        sweep(0, 0, "R2");
        // Idle write: the next request uses the new table
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = 8'd64;
        @(negedge clk);
        base_wr_en   = 1'b0;
        sweep(64, 1, "R10");
        // Idle write in the same cycle as acceptance
        @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = 8'd0;
        req_valid    = 1'b1;
        req_vaddr    = {5'd7, 12'h010};
        req_kind     = 2'b00;
        @(negedge clk);
        base_wr_en   = 1'b0;
        req_valid    = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(cap_addr == 8'd7, "R10", "same-cycle base write", int'(cap_addr), 7);
        // Busy writes: the current walk keeps the old base, the next one uses the new
        xlate(9, 0, 12'h123, 4, 0, 0, "R11", 1'b1, 64);
        xlate(9, 0, 12'h456, 2, 64, 1, "R11", 1'b0, 0);
        xlate(20, 2, 12'h789, 3, 64, 1, "R11", 1'b1, 0);
        xlate(20, 2, 12'h0ab, 1, 0, 0, "R11", 1'b0, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule